// File: doc/BRIEF.md
# Counter Channel Byte-Pointer Register Front End

This block is the host-facing register interface of one counter channel. It sits on an 8-bit bus and shows two locations: a data location (even offset) and a control location (odd offset). A byte written to the control location is a command. Its top field picks either an action decoder or one of three configuration registers: counting mode, input/output control and index control. Action commands fire single-cycle strobes toward the counting logic (clear counter, clear flags, clear error, load preset into counter), capture the live count into an output latch, copy the low preset byte into the filter clock prescaler, or reset the byte pointer.

Multi-byte values pass through a single byte pointer, least-significant byte first. Data writes fill the 24-bit preset. Data reads drain the output latch. Writes and reads share the one pointer, which wraps after the third byte. A read of the control location returns the channel's status flags. The counting logic itself lies outside the block: it consumes the preset, the strobes and the configuration fields, and it supplies the count and the flags.

Top module: `ctr_reg_front`

## Requirements
- R1: After reset the preset, output latch, prescaler, byte pointer and all configuration fields are zero, and every strobe is low.
- R2: `addr`=0 selects the data location and `addr`=1 the control location. A data write changes only the preset, and a control write never changes the preset.
- R3: Command bits 6:5 choose the target: 00 action decoder, 01 mode register, 10 I/O control register, 11 index control register. Bit 7 is ignored. A command for one target leaves the other registers unchanged.
- R4: In an action command (bits 6:5 = 00), bit 0 returns the byte pointer to byte 0 before the next data access.
- R5: In an action command, bits 2:1 = 01 pulse `clr_count`, 10 pulse `clr_flags` and 11 pulse `clr_error`. Each pulse is high for exactly the one cycle after the write edge.
- R6: In an action command, bits 4:3 = 01 pulse `load_count` for one cycle, 10 capture `count_val` into the output latch at the write edge, and 11 copy preset bits 7:0 into `prescale`.
- R7: Three successive data writes place bytes into preset bits 7:0, then 15:8, then 23:16.
- R8: Successive data reads return latch bits 7:0, then 15:8, then 23:16. The latch keeps its value until the next capture command, whatever `count_val` does.
- R9: The byte pointer advances on every data write and every data read. It wraps from byte 2 back to byte 0, and reads and writes share it.
- R10: Mode register: count mode from bits 2:1, quadrature select from bits 4:3. I/O register: A/B enable from bit 0, preset-on-index from bit 1, flag function from bits 4:3. Index register: synchronous enable from bit 0, polarity from bit 1.
- R11: A control read returns borrow toggle in bit 0, carry toggle in bit 1, error in bit 4 and up/down in bit 5, with all other bits zero.
- R12: One action command may combine a pointer reset (bit 0) with a transfer (bits 4:3). Both take effect at the same edge, so the next read returns latch byte 0 of the new capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 1 | 0 = data location, 1 = control location |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| wdata | input | 8 | Bus write data |
| rdata | output | 8 | Bus read data (combinational, valid while rd_en is high) |
| count_val | input | 24 | Live count from the counting logic |
| st_borrow | input | 1 | Borrow toggle flag |
| st_carry | input | 1 | Carry toggle flag |
| st_error | input | 1 | Error flag |
| st_up | input | 1 | Count direction, 1 = up |
| preset | output | 24 | Preset value |
| prescale | output | 8 | Filter clock prescaler |
| clr_count | output | 1 | Clear-counter strobe |
| clr_flags | output | 1 | Clear carry/borrow/compare/sign strobe |
| clr_error | output | 1 | Clear-error strobe |
| load_count | output | 1 | Preset-to-counter strobe |
| cnt_mode | output | 2 | Count mode |
| quad_sel | output | 2 | Quadrature select |
| ab_enable | output | 1 | A/B input enable |
| idx_preset | output | 1 | Preset-on-index select |
| flag_fn | output | 2 | Flag output function |
| idx_sync | output | 1 | Index synchronous enable |
| idx_pol | output | 1 | Index polarity |

## Verification
The hardest state to reach is a byte pointer left mid-sequence by one access type and then used by the other. The test only shows that writes and reads share one pointer if a partial read run is followed by a write and then a read lands on the byte the write left behind. The stimulus gets there by deliberately breaking the three-byte rhythm. It does a four-read run to cross the wrap, changes the live count without a capture to show the latch holds, resets the pointer, makes one write, and then reads; only a single shared pointer yields the middle latch byte on that read. The combined reset-and-capture command is applied after a wrap has left the pointer off zero, so a pointer reset that came late would be visible.

// File: rtl/ctr_reg_pkg.sv
package ctr_reg_pkg;

  typedef enum logic [1:0] {
    TGT_ACTION = 2'b00,
    TGT_MODE   = 2'b01,
    TGT_IOCTL  = 2'b10,
    TGT_INDEX  = 2'b11
  } target_e;

  typedef struct packed {
    logic ptr_rst;
    logic clr_cnt;
    logic clr_flg;
    logic clr_err;
    logic ld_cnt;
    logic cap_lat;
    logic ld_psc;
    logic wr_mode;
    logic wr_ioc;
    logic wr_idx;
  } cmd_dec_t;

endpackage

// File: rtl/ctr_cmd_decode.sv
module ctr_cmd_decode
  import ctr_reg_pkg::*;
(
  input  logic       cmd_we,
  input  logic [6:0] cmd,
  output cmd_dec_t   dec
);

  target_e tgt;
  logic    act;

  assign tgt = target_e'(cmd[6:5]);
  assign act = cmd_we && (tgt == TGT_ACTION);

  always_comb begin
    dec         = '0;
    dec.ptr_rst = act && cmd[0];
    dec.clr_cnt = act && (cmd[2:1] == 2'b01);
    dec.clr_flg = act && (cmd[2:1] == 2'b10);
    dec.clr_err = act && (cmd[2:1] == 2'b11);
    dec.ld_cnt  = act && (cmd[4:3] == 2'b01);
    dec.cap_lat = act && (cmd[4:3] == 2'b10);
    dec.ld_psc  = act && (cmd[4:3] == 2'b11);
    dec.wr_mode = cmd_we && (tgt == TGT_MODE);
    dec.wr_ioc  = cmd_we && (tgt == TGT_IOCTL);
    dec.wr_idx  = cmd_we && (tgt == TGT_INDEX);
  end

endmodule

// File: rtl/ctr_byte_ptr.sv
module ctr_byte_ptr #(
  parameter int NBYTES = 3,
  parameter int PTR_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  output logic [PTR_W-1:0] ptr
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(NBYTES - 1);

  logic [PTR_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (clr)      ptr_d = '0;
    else if (adv) ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= LAST); // R9
  AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ptr_q == '0)); // R4
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && ptr_q == LAST) |=> (ptr_q == '0)); // R9
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr) |=> $stable(ptr_q)); // R9

endmodule

// File: rtl/ctr_data_regs.sv
module ctr_data_regs #(
  parameter int DATA_W = 8,
  parameter int NBYTES = 3,
  parameter int PTR_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1,
  localparam int VAL_W = DATA_W * NBYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dat_we,
  input  logic [PTR_W-1:0]  ptr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cap_lat,
  input  logic              ld_psc,
  input  logic [VAL_W-1:0]  count_val,
  output logic [VAL_W-1:0]  preset,
  output logic [VAL_W-1:0]  latch,
  output logic [DATA_W-1:0] prescale
);

  logic [NBYTES-1:0][DATA_W-1:0] pre_q, pre_d;
  logic [VAL_W-1:0]              lat_q, lat_d;
  logic [DATA_W-1:0]             psc_q, psc_d;

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    always_comb begin
      pre_d[i] = pre_q[i];
      if (dat_we && ptr == PTR_W'(i)) pre_d[i] = wdata;
    end
  end

  always_comb begin
    lat_d = lat_q;
    psc_d = psc_q;
    if (cap_lat) lat_d = count_val;
    if (ld_psc)  psc_d = pre_q[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      lat_q <= '0;
      psc_q <= '0;
    end else begin
      pre_q <= pre_d;
      lat_q <= lat_d;
      psc_q <= psc_d;
    end
  end

  assign preset   = pre_q;
  assign latch    = lat_q;
  assign prescale = psc_q;

  AST_LATCH_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_lat |=> (lat_q == $past(count_val))); // R6
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_lat |=> $stable(lat_q)); // R8
  AST_PRESET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_we |=> $stable(pre_q)); // R2

endmodule

// File: rtl/ctr_reg_front.sv
module ctr_reg_front
  import ctr_reg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NBYTES = 3,
  localparam int VAL_W = DATA_W * NBYTES,
  localparam int PTR_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [VAL_W-1:0]  count_val,
  input  logic              st_borrow,
  input  logic              st_carry,
  input  logic              st_error,
  input  logic              st_up,
  output logic [VAL_W-1:0]  preset,
  output logic [DATA_W-1:0] prescale,
  output logic              clr_count,
  output logic              clr_flags,
  output logic              clr_error,
  output logic              load_count,
  output logic [1:0]        cnt_mode,
  output logic [1:0]        quad_sel,
  output logic              ab_enable,
  output logic              idx_preset,
  output logic [1:0]        flag_fn,
  output logic              idx_sync,
  output logic              idx_pol
);

  logic             ctl_we, dat_we, dat_re;
  cmd_dec_t         dec;
  logic [PTR_W-1:0] ptr;
  logic [VAL_W-1:0] latch;

  assign ctl_we = wr_en && addr;
  assign dat_we = wr_en && !addr;
  assign dat_re = rd_en && !addr;

  ctr_cmd_decode u_dec (
    .cmd_we (ctl_we),
    .cmd    (wdata[6:0]),
    .dec    (dec)
  );

  ctr_byte_ptr #(.NBYTES(NBYTES), .PTR_W(PTR_W)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (dec.ptr_rst),
    .adv   (dat_we || dat_re),
    .ptr   (ptr)
  );

  ctr_data_regs #(.DATA_W(DATA_W), .NBYTES(NBYTES), .PTR_W(PTR_W)) u_data (
    .clk       (clk),
    .rst_n     (rst_n),
    .dat_we    (dat_we),
    .ptr       (ptr),
    .wdata     (wdata),
    .cap_lat   (dec.cap_lat),
    .ld_psc    (dec.ld_psc),
    .count_val (count_val),
    .preset    (preset),
    .latch     (latch),
    .prescale  (prescale)
  );

  // configuration registers and strobes
  logic [3:0] mode_q, mode_d;
  logic [3:0] ioc_q,  ioc_d;
  logic [1:0] idx_q,  idx_d;
  logic [3:0] stb_q,  stb_d;

  always_comb begin
    mode_d = mode_q;
    ioc_d  = ioc_q;
    idx_d  = idx_q;
    if (dec.wr_mode) mode_d = {wdata[4:3], wdata[2:1]};
    if (dec.wr_ioc)  ioc_d  = {wdata[4:3], wdata[1], wdata[0]};
    if (dec.wr_idx)  idx_d  = {wdata[1], wdata[0]};
    stb_d = {dec.ld_cnt, dec.clr_err, dec.clr_flg, dec.clr_cnt};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ioc_q  <= '0;
      idx_q  <= '0;
      stb_q  <= '0;
    end else begin
      mode_q <= mode_d;
      ioc_q  <= ioc_d;
      idx_q  <= idx_d;
      stb_q  <= stb_d;
    end
  end

  assign cnt_mode   = mode_q[1:0];
  assign quad_sel   = mode_q[3:2];
  assign ab_enable  = ioc_q[0];
  assign idx_preset = ioc_q[1];
  assign flag_fn    = ioc_q[3:2];
  assign idx_sync   = idx_q[0];
  assign idx_pol    = idx_q[1];
  assign clr_count  = stb_q[0];
  assign clr_flags  = stb_q[1];
  assign clr_error  = stb_q[2];
  assign load_count = stb_q[3];

  // read path
  logic [DATA_W-1:0] status_byte, latch_byte;

  always_comb begin
    status_byte    = '0;
    status_byte[0] = st_borrow;
    status_byte[1] = st_carry;
    status_byte[4] = st_error;
    status_byte[5] = st_up;
    latch_byte     = latch[DATA_W*ptr +: DATA_W];
    rdata          = addr ? status_byte : latch_byte;
  end

  AST_STROBE_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_count || clr_flags || clr_error || load_count) |-> $past(ctl_we)); // R5
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({clr_count, clr_flags, clr_error})); // R5
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_we && wdata[6:5] == 2'b01) |=> $stable({cnt_mode, quad_sel})); // R10
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_we && wdata[6:5] == 2'b11) |=> $stable({idx_sync, idx_pol})); // R3
  AST_CTL_PRESET_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> $stable(preset)); // R2

endmodule

// File: tb/sim_ctr_reg_front.sv
module sim_ctr_reg_front;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [23:0] count_val = '0;
  logic        st_borrow = 1'b0, st_carry = 1'b0, st_error = 1'b0, st_up = 1'b0;
  logic [23:0] preset;
  logic [7:0]  prescale;
  logic        clr_count, clr_flags, clr_error, load_count;
  logic [1:0]  cnt_mode, quad_sel, flag_fn;
  logic        ab_enable, idx_preset, idx_sync, idx_pol;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ctr_reg_front u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .count_val(count_val),
    .st_borrow(st_borrow), .st_carry(st_carry), .st_error(st_error), .st_up(st_up),
    .preset(preset), .prescale(prescale), .clr_count(clr_count),
    .clr_flags(clr_flags), .clr_error(clr_error), .load_count(load_count),
    .cnt_mode(cnt_mode), .quad_sel(quad_sel), .ab_enable(ab_enable),
    .idx_preset(idx_preset), .flag_fn(flag_fn), .idx_sync(idx_sync), .idx_pol(idx_pol)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_op(input logic w, input logic a, input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = w; rd_en = !w; addr = a; wdata = d;
  endtask

  task automatic idle();
    @(posedge clk); #1;
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic rd_exp(input logic a, input logic [7:0] e, input string req);
    exp_q.push_back(e);
    tag_q.push_back(req);
    bus_op(1'b0, a, 8'h00);
  endtask

  // monitor: compares read data against the scoreboard queue
  initial begin
    forever begin
      @(negedge clk);
      if (rd_en) begin
        if (exp_q.size() == 0) chk("SCOREBOARD", 32'(rdata), 32'hFFFF_FFFF);
        else chk(tag_q.pop_front(), 32'(rdata), 32'(exp_q.pop_front()));
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle();
    // R1 reset state
    chk("R1 preset", 32'(preset), 0);
    chk("R1 prescale", 32'(prescale), 0);
    chk("R1 config", 32'({cnt_mode, quad_sel, ab_enable, idx_preset, flag_fn, idx_sync, idx_pol}), 0);
    chk("R1 strobes", 32'({clr_count, clr_flags, clr_error, load_count}), 0);
    rd_exp(1'b0, 8'h00, "R1 latch byte0");
    idle();

    // R4 + R7: pointer reset then three writes, LSB first
    bus_op(1'b1, 1'b1, 8'h01);
    bus_op(1'b1, 1'b0, 8'h11);
    bus_op(1'b1, 1'b0, 8'h22);
    bus_op(1'b1, 1'b0, 8'h33);
    idle();
    chk("R7 preset order", 32'(preset), 32'h332211);
    // R9: fourth write wraps to byte 0
    bus_op(1'b1, 1'b0, 8'h44);
    idle();
    chk("R9 write wrap", 32'(preset), 32'h332244);

    // R6: load strobe
    bus_op(1'b1, 1'b1, 8'h08);
    idle();
    chk("R6 load_count pulse", 32'({load_count, clr_count}), 32'b10);
    idle();
    chk("R6 load_count single", 32'(load_count), 0);

    // R12: combined pointer reset + capture (pointer currently at byte 1)
    count_val = 24'hA5C3E1;
    bus_op(1'b1, 1'b1, 8'h11);
    rd_exp(1'b0, 8'hE1, "R12 byte0 after combined");
    rd_exp(1'b0, 8'hC3, "R8 byte1");
    rd_exp(1'b0, 8'hA5, "R8 byte2");
    rd_exp(1'b0, 8'hE1, "R9 read wrap");
    count_val = 24'h000000;
    rd_exp(1'b0, 8'hC3, "R8 latch holds");
    idle();

    // R9 shared pointer: reset, one write, then read lands on byte 1
    bus_op(1'b1, 1'b1, 8'h01);
    bus_op(1'b1, 1'b0, 8'h55);
    rd_exp(1'b0, 8'hC3, "R9 shared pointer");
    idle();
    chk("R2 data write to preset", 32'(preset), 32'h332255);

    // R5 clear strobes
    bus_op(1'b1, 1'b1, 8'h02);
    idle();
    chk("R5 clr_count", 32'({clr_count, clr_flags, clr_error}), 32'b100);
    bus_op(1'b1, 1'b1, 8'h04);
    idle();
    chk("R5 clr_flags", 32'({clr_count, clr_flags, clr_error}), 32'b010);
    bus_op(1'b1, 1'b1, 8'h06);
    idle();
    chk("R5 clr_error", 32'({clr_count, clr_flags, clr_error}), 32'b001);
    idle();
    chk("R5 strobes drop", 32'({clr_count, clr_flags, clr_error}), 0);

    // R6 prescaler from preset low byte
    bus_op(1'b1, 1'b1, 8'h18);
    idle();
    chk("R6 prescale", 32'(prescale), 32'h55);

    // R3 / R10 configuration registers (bit 7 set, must be ignored)
    bus_op(1'b1, 1'b1, 8'hBA);
    idle();
    chk("R10 mode", 32'({cnt_mode, quad_sel}), 32'b0111);
    chk("R3 others untouched", 32'({ab_enable, idx_preset, flag_fn, idx_sync, idx_pol}), 0);
    bus_op(1'b1, 1'b1, 8'h53);
    idle();
    chk("R10 ioctl", 32'({ab_enable, idx_preset, flag_fn}), 32'b1110);
    bus_op(1'b1, 1'b1, 8'h62);
    idle();
    chk("R10 index", 32'({idx_sync, idx_pol}), 32'b01);
    chk("R3 mode kept", 32'({cnt_mode, quad_sel}), 32'b0111);
    chk("R2 control leaves preset", 32'(preset), 32'h332255);
    bus_op(1'b1, 1'b0, 8'h99);
    idle();
    chk("R2 data write leaves config", 32'({cnt_mode, quad_sel, ab_enable, idx_preset, flag_fn, idx_sync, idx_pol}), 32'b0111_1110_01);

    // R11 status read
    st_borrow = 1'b1; st_carry = 1'b0; st_error = 1'b1; st_up = 1'b1;
    rd_exp(1'b1, 8'h31, "R11 status a");
    idle();
    st_borrow = 1'b0; st_carry = 1'b1; st_error = 1'b0; st_up = 1'b0;
    rd_exp(1'b1, 8'h02, "R11 status b");
    idle();
    idle();
    chk("SCOREBOARD drained", 32'(exp_q.size()), 0);
    finish_run();
  end

endmodule